// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block forms the unsigned product of two operands of `OP_W` bits each. It does not use a full array of partial-product adders. Instead it runs one partial product per clock. On each step it looks at one bit of the multiplier, starting with the least significant bit. When that bit is set, it adds a copy of the multiplicand, shifted to that bit's weight, into a double-width accumulator. One adder of 2·`OP_W` bits is reused on every step. In exchange, each result takes `OP_W` cycles.

The user raises `start` for one cycle while the block is idle, with both operands on the inputs. The block captures the operands, clears its accumulator and raises `busy`. After exactly `OP_W` steps it drops `busy`, pulses `done` for one cycle and places the 2·`OP_W`-bit result on `product`. That value stays put until the next multiplication finishes. A new `start` is accepted as early as the cycle in which `done` is high.

Top module: `seq_mult`

## Requirements
- R1: While reset is held and after it is released, `busy` is 0, `done` is 0 and `product` is 0.
- R2: A `start` sampled high while `busy` is 0 captures `op_a` and `op_b` at that edge and clears the accumulator. `busy` is 1 from the next cycle.
- R3: After an accepted start, `busy` stays 1 for exactly `OP_W` cycles. `done` is 1 in the one cycle right after that, with `busy` 0, and is 0 again in the cycle after.
- R4: When `done` is 1, `product` equals `op_a × op_b` as captured at the start, as an unsigned 2·`OP_W`-bit number. For example, with `OP_W`=4, 3 × 5 gives 15 (`00001111`).
- R5: While `busy` is 1, `start` and any change on `op_a` or `op_b` have no effect. Both the completion time and the result are those of the accepted operands.
- R6: `product` changes only in a cycle in which `done` is 1. It keeps its value while idle and throughout the next multiplication.
- R7: Operands at full scale give the full-width result without truncation: (2^`OP_W`−1)² for `OP_W`=8 is 65025.
- R8: A `start` in the cycle in which `done` is 1 is accepted. The new result does not depend on the previous one.
- R9: An operand of zero in either position gives a product of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a multiplication (taken only when idle) |
| op_a | input | OP_W | Multiplicand, captured on an accepted start |
| op_b | input | OP_W | Multiplier, captured on an accepted start |
| busy | output | 1 | High while the steps are running |
| done | output | 1 | One-cycle pulse when the result is ready |
| product | output | 2·OP_W | Unsigned product, held between completions |

## Verification
The bench measures the length of the busy window against `OP_W` exactly. A step counter that is off by one shows up as `done` one cycle early or late, or as a product missing its top partial product. The bench pulses `start` and changes the operands in the middle of a run. A design that reloads while busy restarts or returns the wrong operands' product. The bench starts again on the `done` cycle, right after a full-scale product. If the accumulator is not cleared, the old sum leaks into the next result. If back-to-back starts are refused, `busy` never rises. Operands at full scale and zero operands test the top carry and the all-skip case. All 4-bit pairs, plus a random sample of 8-bit pairs, test the arithmetic in general.

// File: rtl/seq_mult_pkg.sv
package seq_mult_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;
endpackage

// File: rtl/mult_step_ctrl.sv
module mult_step_ctrl
  import seq_mult_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step_en,
  output logic last_step,
  output logic busy,
  output logic done
);
  localparam int CNT_W = (OP_W > 1) ? $clog2(OP_W) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OP_W - 1);

  run_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  assign busy      = (state_q == ST_RUN);
  assign load      = start && (state_q == ST_IDLE);
  assign step_en   = (state_q == ST_RUN);
  assign last_step = (state_q == ST_RUN) && (cnt_q == LAST_CNT);
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
          end
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST_CNT) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: an accepted start opens a run at step zero
  assert_start_opens_run_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && cnt_q == '0));

  // R3: a run continues until its final step
  assert_run_continues_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && !last_step) |=> busy);

  // R3: done is a single-cycle pulse
  assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3: done follows the last step and coincides with idle
  assert_done_after_last_R3: assert property (@(posedge clk) disable iff (rst)
    last_step |=> (done && !busy));

  // R5: start while running does not restart the count
  assert_no_restart_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && !last_step) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/mult_wide_adder.sv
module mult_wide_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] sum,
  output logic         carry_out
);
  always_comb begin
    logic cy;
    cy = 1'b0;
    for (int i = 0; i < W; i++) begin
      sum[i] = x[i] ^ y[i] ^ cy;
      cy     = (x[i] & y[i]) | (cy & (x[i] ^ y[i]));
    end
    carry_out = cy;
  end
endmodule

// File: rtl/mult_datapath.sv
module mult_datapath #(
  parameter int OP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step_en,
  input  logic              last_step,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  output logic [2*OP_W-1:0] prod
);
  localparam int PW = 2 * OP_W;

  logic [PW-1:0]   mcand_q;
  logic [OP_W-1:0] mplier_q;
  logic [PW-1:0]   acc_q;
  logic [PW-1:0]   prod_q;
  logic [PW-1:0]   addend;
  logic [PW-1:0]   acc_next;
  logic            acc_carry;

  assign addend = mplier_q[0] ? mcand_q : '0;

  mult_wide_adder #(.W(PW)) u_adder (
    .x         (acc_q),
    .y         (addend),
    .sum       (acc_next),
    .carry_out (acc_carry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      acc_q    <= '0;
      prod_q   <= '0;
    end else if (load) begin
      mcand_q  <= {{OP_W{1'b0}}, op_a};
      mplier_q <= op_b;
      acc_q    <= '0;
    end else if (step_en) begin
      acc_q    <= acc_next;
      mcand_q  <= mcand_q << 1;
      mplier_q <= mplier_q >> 1;
      if (last_step) prod_q <= acc_next;
    end
  end

  assign prod = prod_q;

  // R2: the accumulator starts every product from zero
  assert_acc_cleared_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (acc_q == '0));

  // R7: the running sum never overflows the double-width accumulator
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    step_en |-> !acc_carry);

  // R4: every multiplier bit has been consumed once the run ends
  assert_mplier_drained_R4: assert property (@(posedge clk) disable iff (rst)
    last_step |=> (mplier_q == '0));

  // R6: the result register moves only on the final step
  assert_prod_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !last_step |=> $stable(prod_q));
endmodule

// File: rtl/seq_mult.sv
module seq_mult #(
  parameter int OP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  output logic              busy,
  output logic              done,
  output logic [2*OP_W-1:0] product
);
  logic load;
  logic step_en;
  logic last_step;

  mult_step_ctrl #(.OP_W(OP_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .load      (load),
    .step_en   (step_en),
    .last_step (last_step),
    .busy      (busy),
    .done      (done)
  );

  mult_datapath #(.OP_W(OP_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .step_en   (step_en),
    .last_step (last_step),
    .op_a      (op_a),
    .op_b      (op_b),
    .prod      (product)
  );

  // R6: a new product is published only with the done pulse
  assert_product_with_done_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(product) |-> done);
endmodule

// File: tb/test_seq_mult.sv
module test_seq_mult;
  localparam int N  = 8;
  localparam int NS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int checks   = 0;
  int failures = 0;

  logic          start = 1'b0;
  logic [N-1:0]  op_a  = '0;
  logic [N-1:0]  op_b  = '0;
  logic          busy, done;
  logic [2*N-1:0] product;

  logic           s_start = 1'b0;
  logic [NS-1:0]  s_a = '0;
  logic [NS-1:0]  s_b = '0;
  logic           s_busy, s_done;
  logic [2*NS-1:0] s_product;

  seq_mult #(.OP_W(N)) i_seq_mult (
    .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
    .busy(busy), .done(done), .product(product)
  );

  seq_mult #(.OP_W(NS)) i_seq_mult_small (
    .clk(clk), .rst(rst), .start(s_start), .op_a(s_a), .op_b(s_b),
    .busy(s_busy), .done(s_done), .product(s_product)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Issue one start, verify the busy window and the done pulse, return the product.
  task automatic mul8(input logic [N-1:0] a, input logic [N-1:0] b, output logic [2*N-1:0] p);
    bit win_ok;
    @(negedge clk);
    start = 1'b1; op_a = a; op_b = b;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R2 busy after start", 32'(busy), 1);
    win_ok = 1'b1;
    for (int k = 1; k < N; k++) begin
      @(negedge clk);
      if (busy !== 1'b1 || done !== 1'b0) win_ok = 1'b0;
    end
    chk(win_ok, "R3 busy held for OP_W cycles", 32'(win_ok), 1);
    @(negedge clk);
    chk(done === 1'b1 && busy === 1'b0, "R3 done after OP_W steps", {30'd0, done, busy}, 2);
    p = product;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && product === '0, "R1 outputs during reset",
        32'(product), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && product === '0, "R1 outputs after reset",
        {14'd0, busy, done, product}, 0);
    chk(s_busy === 1'b0 && s_done === 1'b0 && s_product === '0, "R1 small instance after reset",
        32'(s_product), 0);
  endtask

  task automatic t_handshake();
    logic [2*N-1:0] p;
    mul8(8'd3, 8'd5, p);
    chk(p === 16'd15, "R4 3x5", 32'(p), 15);
    @(negedge clk);
    chk(done === 1'b0, "R3 done falls after one cycle", 32'(done), 0);
  endtask

  task automatic t_ignore_while_busy();
    bit win_ok;
    @(negedge clk);
    start = 1'b1; op_a = 8'd200; op_b = 8'd100;
    @(negedge clk);
    start = 1'b0;
    win_ok = 1'b1;
    for (int k = 1; k < N; k++) begin
      start = (k == 2 || k == 5) ? 1'b1 : 1'b0;
      op_a  = 8'(k * 37);
      op_b  = 8'(k * 11 + 3);
      @(negedge clk);
      if (busy !== 1'b1) win_ok = 1'b0;
    end
    start = 1'b0;
    chk(win_ok, "R5 busy window not restarted", 32'(win_ok), 1);
    @(negedge clk);
    chk(done === 1'b1, "R5 completion at original time", 32'(done), 1);
    chk(product === 16'd20000, "R5 result of accepted operands", 32'(product), 20000);
  endtask

  task automatic t_hold();
    logic [2*N-1:0] ref_p;
    bit stable_ok;
    mul8(8'd77, 8'd9, ref_p);
    chk(ref_p === 16'd693, "R4 77x9", 32'(ref_p), 693);
    stable_ok = 1'b1;
    for (int k = 0; k < 20; k++) begin
      op_a = 8'(k * 13); op_b = 8'(255 - k);
      @(negedge clk);
      if (product !== 16'd693 || busy !== 1'b0) stable_ok = 1'b0;
    end
    chk(stable_ok, "R6 product held while idle", 32'(product), 693);
    @(negedge clk);
    start = 1'b1; op_a = 8'd2; op_b = 8'd2;
    @(negedge clk);
    start = 1'b0;
    stable_ok = 1'b1;
    for (int k = 0; k < N - 1; k++) begin
      if (product !== 16'd693) stable_ok = 1'b0;
      @(negedge clk);
    end
    chk(stable_ok && product === 16'd693, "R6 product held during next run", 32'(product), 693);
    @(negedge clk);
    chk(product === 16'd4, "R6 product updated with done", 32'(product), 4);
  endtask

  task automatic t_extremes();
    logic [2*N-1:0] p;
    mul8(8'd255, 8'd255, p);
    chk(p === 16'd65025, "R7 full-scale operands", 32'(p), 65025);
    mul8(8'd0, 8'd200, p);
    chk(p === 16'd0, "R9 zero multiplicand", 32'(p), 0);
    mul8(8'd200, 8'd0, p);
    chk(p === 16'd0, "R9 zero multiplier", 32'(p), 0);
    mul8(8'd128, 8'd128, p);
    chk(p === 16'd16384, "R7 top multiplier bit", 32'(p), 16384);
  endtask

  task automatic t_back_to_back();
    logic [2*N-1:0] p;
    bit win_ok;
    mul8(8'd255, 8'd255, p);
    start = 1'b1; op_a = 8'd1; op_b = 8'd1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R8 start on done cycle accepted", 32'(busy), 1);
    win_ok = 1'b1;
    for (int k = 1; k < N; k++) begin
      @(negedge clk);
      if (busy !== 1'b1) win_ok = 1'b0;
    end
    chk(win_ok, "R8 back-to-back busy window", 32'(win_ok), 1);
    @(negedge clk);
    chk(done === 1'b1 && product === 16'd1, "R8 result independent of previous", 32'(product), 1);
  endtask

  task automatic t_exhaustive_small();
    int bad = 0;
    logic [2*NS-1:0] exp_p;
    for (int a = 0; a < (1 << NS); a++) begin
      for (int b = 0; b < (1 << NS); b++) begin
        @(negedge clk);
        s_start = 1'b1; s_a = NS'(a); s_b = NS'(b);
        @(negedge clk);
        s_start = 1'b0;
        repeat (NS) @(negedge clk);
        exp_p = 8'(a * b);
        if (s_done !== 1'b1 || s_product !== exp_p) begin
          if (bad == 0)
            $display("FAIL R4 small %0dx%0d actual=%0d expected=%0d", a, b, s_product, exp_p);
          bad++;
        end
      end
    end
    checks++;
    if (bad != 0) failures++;
    @(negedge clk);
    s_start = 1'b1; s_a = 4'd3; s_b = 4'd5;
    @(negedge clk);
    s_start = 1'b0;
    repeat (NS) @(negedge clk);
    chk(s_product === 8'b0000_1111, "R4 small 3x5", 32'(s_product), 15);
  endtask

  task automatic t_random();
    int bad = 0;
    logic [2*N-1:0] p;
    logic [N-1:0] a, b;
    for (int k = 0; k < 300; k++) begin
      a = N'($urandom);
      b = N'($urandom);
      mul8(a, b, p);
      if (p !== 16'(a) * 16'(b)) begin
        if (bad == 0)
          $display("FAIL R4 random %0dx%0d actual=%0d expected=%0d", a, b, p, 16'(a) * 16'(b));
        bad++;
      end
    end
    checks++;
    if (bad != 0) failures++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_handshake();
    t_ignore_while_busy();
    t_hold();
    t_extremes();
    t_back_to_back();
    t_exhaustive_small();
    t_random();
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule